// File: doc/BRIEF.md
# Carrier Integrity Monitor

This block decides, from the outcome of each received carrier event, whether a link can be trusted. A receive front end pulses `evt_stb` once per carrier event and marks it good or bad on `evt_good`. A bad event is one that held invalid code groups. After a run of bad events of programmable length, the link is held to be unstable. While it is unstable, the block cuts both MII streams. Receive words are dropped before they reach the MII side, and words the MII side offers for transmission are taken and thrown away. The block keeps judging every carrier event while it is unstable. After a programmable run of good events it declares the link stable again and both streams flow as before.

Each entry into the unstable state raises a sticky flag and adds one to a disconnect counter. A management read clears the flag, but only once the link is stable again. The counter stops at its maximum value and clears when it is read. A disable control turns the whole function off. Its reset value comes from a strap pin: a repeater strap enables the monitor and a node strap disables it. Software may rewrite the control at any time after reset.

The two streams are valid/ready pass-throughs with no storage. When the link is stable, valid, data and ready pass straight through, and the sink's back-pressure reaches the source unchanged. When the link is unstable, the sink sees no valid words, and the source sees ready held high so that its words are discarded rather than stalled.

Top module: `carrier_integrity_monitor`

## Requirements
- R1: Synchronous reset (`rst_n` low at a clock edge) clears `link_unstable`, `status_flag` and `disc_count`, and loads `cim_off` with the inverse of `strap_repeater`, so strap 1 gives `cim_off`=0 and strap 0 gives `cim_off`=1.
- R2: A clock edge with `cfg_wr`=1 loads `cim_off` from `cfg_off`, whatever the strap.
- R3: While stable and enabled, `link_unstable` rises after the edge that takes the Nth consecutive event with `evt_good`=0, where N is `bad_th`. A value of 0 in `bad_th` acts as 1. An event with `evt_good`=1 restarts the run.
- R4: While `link_unstable`=1, `rx_out_valid` and `tx_out_valid` are 0 and `rx_in_ready` and `tx_in_ready` are 1. While it is 0, each out_valid equals its in_valid, each out_data equals its in_data, and each in_ready equals its out_ready.
- R5: While unstable, events are still judged. `link_unstable` falls after the edge that takes the Mth consecutive event with `evt_good`=1, where M is `good_th`. A value of 0 in `good_th` acts as 1. A bad event restarts that run.
- R6: `status_flag` becomes 1 at the edge that makes the link unstable. A `rd_status` pulse clears it only if the link is stable at that edge and is not being made unstable at that same edge. A read while the link is unstable leaves the flag at 1.
- R7: `disc_count` rises by one at each entry into the unstable state and holds at all ones (255 with the default width) when it is full.
- R8: A `rd_count` pulse clears `disc_count`. If the pulse falls on an edge where an entry also happens, the result is 1.
- R9: While `cim_off`=1, bad events never make the link unstable, never gate the streams, and do not change `status_flag` or `disc_count`. Setting `cim_off` while the link is unstable returns `link_unstable` to 0 by the second edge after the write, and that return does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_repeater | input | 1 | Mode strap: 1 selects repeater, so the monitor is enabled at reset |
| cfg_wr | input | 1 | Write strobe for the disable control |
| cfg_off | input | 1 | Value written into the disable control |
| bad_th | input | TH_W | Length of the bad-event run that marks the link unstable (0 acts as 1) |
| good_th | input | TH_W | Length of the good-event run that marks the link stable (0 acts as 1) |
| evt_stb | input | 1 | One-cycle pulse per received carrier event |
| evt_good | input | 1 | The event had only valid code groups |
| rd_status | input | 1 | Management read of the status flag (clears it when stable) |
| rd_count | input | 1 | Management read of the disconnect counter (clears it) |
| rx_in_valid | input | 1 | Receive stream from the PHY side: valid |
| rx_in_data | input | DATA_W | Receive stream from the PHY side: data |
| rx_in_ready | output | 1 | Receive stream from the PHY side: ready |
| rx_out_valid | output | 1 | Receive stream toward the MII: valid |
| rx_out_data | output | DATA_W | Receive stream toward the MII: data |
| rx_out_ready | input | 1 | Receive stream toward the MII: ready |
| tx_in_valid | input | 1 | Transmit stream from the MII: valid |
| tx_in_data | input | DATA_W | Transmit stream from the MII: data |
| tx_in_ready | output | 1 | Transmit stream from the MII: ready |
| tx_out_valid | output | 1 | Transmit stream toward the PHY side: valid |
| tx_out_data | output | DATA_W | Transmit stream toward the PHY side: data |
| tx_out_ready | input | 1 | Transmit stream toward the PHY side: ready |
| cim_off | output | 1 | Current value of the disable control |
| link_unstable | output | 1 | The link is currently judged unstable |
| status_flag | output | 1 | Sticky unstable-link flag |
| disc_count | output | CNT_W | Disconnect counter |

## Verification
An event, a read or a control write is taken at one clock edge. `link_unstable`, `status_flag`, `disc_count` and `cim_off` show the result right after that edge. The stream gating follows `link_unstable` with no further delay. The one exception is a disable write: it reaches `link_unstable` one edge later, because the judge sees the control only after the control register has loaded. The bench drives every stimulus on the falling edge and holds it for exactly one rising edge. It checks at the next falling edge, or at the second one for a disable write, so each check lands in the cycle where the result is first due.

// File: rtl/cim_pkg.sv
package cim_pkg;
  typedef enum logic {
    LINK_OK    = 1'b0,
    LINK_FLAKY = 1'b1
  } link_state_e;
endpackage

// File: rtl/cim_cfg.sv
// Disable control: loaded from the strap during reset, writable afterwards.
module cim_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_repeater,
  input  logic wr_en,
  input  logic wr_val,
  output logic off_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     off_q <= ~strap_repeater;
    else if (wr_en) off_q <= wr_val;
  end
endmodule

// File: rtl/cim_judge.sv
// Run-length judge: consecutive bad events destabilise, consecutive good events restore.
module cim_judge
  import cim_pkg::*;
#(
  parameter int TH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            off_i,
  input  logic            evt_stb,
  input  logic            evt_good,
  input  logic [TH_W-1:0] bad_th,
  input  logic [TH_W-1:0] good_th,
  output logic            flaky_o,
  output logic            enter_o
);
  localparam logic [TH_W-1:0] ONE = TH_W'(1);

  link_state_e     st_q, st_d;
  logic [TH_W-1:0] run_q, run_d;
  logic [TH_W-1:0] bad_lim, good_lim, run_inc;

  assign bad_lim  = (bad_th  == '0) ? ONE : bad_th;
  assign good_lim = (good_th == '0) ? ONE : good_th;
  assign run_inc  = run_q + ONE;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (off_i) begin
      st_d  = LINK_OK;
      run_d = '0;
    end else if (evt_stb) begin
      case (st_q)
        LINK_OK: begin
          if (evt_good) begin
            run_d = '0;
          end else if (run_inc >= bad_lim) begin
            st_d  = LINK_FLAKY;
            run_d = '0;
          end else begin
            run_d = run_inc;
          end
        end
        default: begin
          if (!evt_good) begin
            run_d = '0;
          end else if (run_inc >= good_lim) begin
            st_d  = LINK_OK;
            run_d = '0;
          end else begin
            run_d = run_inc;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LINK_OK;
      run_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign flaky_o = (st_q == LINK_FLAKY);
  assign enter_o = (st_q == LINK_OK) && (st_d == LINK_FLAKY);
endmodule

// File: rtl/cim_status.sv
// Sticky flag (cleared by read only when stable) and saturating disconnect counter.
module cim_status #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter_i,
  input  logic             flaky_i,
  input  logic             rd_status,
  input  logic             rd_count,
  output logic             flag_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_base;

  assign cnt_base = rd_count ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (enter_i)                    flag_q <= 1'b1;
      else if (rd_status && !flaky_i) flag_q <= 1'b0;

      if (enter_i && cnt_base != CNT_MAX) cnt_q <= cnt_base + 1'b1;
      else                                cnt_q <= cnt_base;
    end
  end
endmodule

// File: rtl/cim_gate.sv
// Stream gate without storage: pass-through when open, drain (drop) when blocked.
module cim_gate #(
  parameter int DATA_W = 8
) (
  input  logic              blk,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  assign out_valid = in_valid & ~blk;
  assign out_data  = in_data;
  assign in_ready  = out_ready | blk;
endmodule

// File: rtl/carrier_integrity_monitor.sv
module carrier_integrity_monitor #(
  parameter int TH_W   = 4,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_repeater,
  input  logic              cfg_wr,
  input  logic              cfg_off,
  input  logic [TH_W-1:0]   bad_th,
  input  logic [TH_W-1:0]   good_th,
  input  logic              evt_stb,
  input  logic              evt_good,
  input  logic              rd_status,
  input  logic              rd_count,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              rx_out_ready,
  input  logic              tx_in_valid,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_in_ready,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  output logic              cim_off,
  output logic              link_unstable,
  output logic              status_flag,
  output logic [CNT_W-1:0]  disc_count
);
  localparam int NDIR = 2;

  logic off_q, flaky, enter;
  logic              g_in_valid  [NDIR];
  logic [DATA_W-1:0] g_in_data   [NDIR];
  logic              g_in_ready  [NDIR];
  logic              g_out_valid [NDIR];
  logic [DATA_W-1:0] g_out_data  [NDIR];
  logic              g_out_ready [NDIR];

  cim_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_repeater(strap_repeater),
    .wr_en(cfg_wr), .wr_val(cfg_off), .off_q(off_q)
  );

  cim_judge #(.TH_W(TH_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .off_i(off_q),
    .evt_stb(evt_stb), .evt_good(evt_good),
    .bad_th(bad_th), .good_th(good_th),
    .flaky_o(flaky), .enter_o(enter)
  );

  cim_status #(.CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .enter_i(enter), .flaky_i(flaky),
    .rd_status(rd_status), .rd_count(rd_count),
    .flag_q(status_flag), .cnt_q(disc_count)
  );

  // direction 0 = receive, 1 = transmit
  assign g_in_valid[0]  = rx_in_valid;
  assign g_in_data[0]   = rx_in_data;
  assign g_out_ready[0] = rx_out_ready;
  assign g_in_valid[1]  = tx_in_valid;
  assign g_in_data[1]   = tx_in_data;
  assign g_out_ready[1] = tx_out_ready;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    cim_gate #(.DATA_W(DATA_W)) u_gate (
      .blk(flaky),
      .in_valid(g_in_valid[d]), .in_data(g_in_data[d]), .in_ready(g_in_ready[d]),
      .out_valid(g_out_valid[d]), .out_data(g_out_data[d]), .out_ready(g_out_ready[d])
    );
  end

  assign rx_in_ready  = g_in_ready[0];
  assign rx_out_valid = g_out_valid[0];
  assign rx_out_data  = g_out_data[0];
  assign tx_in_ready  = g_in_ready[1];
  assign tx_out_valid = g_out_valid[1];
  assign tx_out_data  = g_out_data[1];

  assign cim_off       = off_q;
  assign link_unstable = flaky;
endmodule

// File: rtl/cim_checker.sv
module cim_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cim_off,
  input logic             link_unstable,
  input logic             status_flag,
  input logic [CNT_W-1:0] disc_count,
  input logic             rd_count,
  input logic             rx_out_valid,
  input logic             tx_out_valid,
  input logic             rx_in_ready,
  input logic             tx_in_ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R4
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_unstable |-> (!rx_out_valid && !tx_out_valid && rx_in_ready && tx_in_ready));

  // R6
  flag_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_unstable) |-> status_flag);

  // R6
  flag_clear_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_flag) |-> !link_unstable);

  // R7
  count_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_unstable) |-> disc_count != '0);

  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_count == CNT_MAX && !rd_count) |=> disc_count == CNT_MAX);

  // R9
  off_no_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cim_off |=> !link_unstable);
endmodule

bind carrier_integrity_monitor cim_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cim_off(cim_off), .link_unstable(link_unstable),
  .status_flag(status_flag), .disc_count(disc_count), .rd_count(rd_count),
  .rx_out_valid(rx_out_valid), .tx_out_valid(tx_out_valid),
  .rx_in_ready(rx_in_ready), .tx_in_ready(tx_in_ready)
);

// File: tb/tb_carrier_integrity_monitor.sv
`timescale 1ns/1ps
module tb_carrier_integrity_monitor;
  localparam int TH_W = 4, CNT_W = 8, DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, strap_repeater = 1'b1, cfg_wr = 1'b0, cfg_off = 1'b0;
  logic [TH_W-1:0] bad_th = 4'd3, good_th = 4'd2;
  logic evt_stb = 1'b0, evt_good = 1'b0, rd_status = 1'b0, rd_count = 1'b0;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b0, tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [DATA_W-1:0] rx_in_data = '0, tx_in_data = '0;
  logic rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic [DATA_W-1:0] rx_out_data, tx_out_data;
  logic cim_off, link_unstable, status_flag;
  logic [CNT_W-1:0] disc_count;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  carrier_integrity_monitor #(.TH_W(TH_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    strap_repeater = strap; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ev(input logic good);
    evt_stb = 1'b1; evt_good = good;
    @(negedge clk);
    evt_stb = 1'b0;
  endtask

  task automatic wr_off(input logic v);
    cfg_wr = 1'b1; cfg_off = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_st();
    rd_status = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
  endtask

  task automatic rd_cn();
    rd_count = 1'b1;
    @(negedge clk);
    rd_count = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R1", "cim_off strap1", cim_off, 0);
    chk("R1", "unstable", link_unstable, 0);
    chk("R1", "status", status_flag, 0);
    chk("R1", "count", disc_count, 0);
    do_reset(1'b0);
    chk("R1", "cim_off strap0", cim_off, 1);
  endtask

  task automatic t_sw_write();
    wr_off(1'b0);
    chk("R2", "cim_off after write 0", cim_off, 0);
    wr_off(1'b1);
    chk("R2", "cim_off after write 1", cim_off, 1);
    wr_off(1'b0);
    @(negedge clk);
  endtask

  task automatic t_enter();
    bad_th = 4'd3; good_th = 4'd2;
    ev(0); ev(0); ev(1); ev(0); ev(0);
    chk("R3", "interrupted run stays stable", link_unstable, 0);
    ev(0);
    chk("R3", "third bad enters", link_unstable, 1);
    chk("R6", "flag set", status_flag, 1);
    chk("R7", "count one", disc_count, 1);
  endtask

  task automatic t_gate_closed();
    rx_in_valid = 1'b1; rx_in_data = 8'h5A; rx_out_ready = 1'b0;
    tx_in_valid = 1'b1; tx_in_data = 8'hC3; tx_out_ready = 1'b0;
    #1;
    chk("R4", "rx_out_valid blocked", rx_out_valid, 0);
    chk("R4", "rx_in_ready drained", rx_in_ready, 1);
    chk("R4", "tx_out_valid blocked", tx_out_valid, 0);
    chk("R4", "tx_in_ready drained", tx_in_ready, 1);
    @(negedge clk);
  endtask

  task automatic t_read_unstable();
    rd_st();
    chk("R6", "read while unstable keeps flag", status_flag, 1);
  endtask

  task automatic t_recover();
    ev(1); ev(0); ev(1);
    chk("R5", "interrupted good run stays unstable", link_unstable, 1);
    ev(1);
    chk("R5", "second good recovers", link_unstable, 0);
    #1;
    chk("R4", "rx valid passes", rx_out_valid, 1);
    chk("R4", "rx data passes", rx_out_data, 8'h5A);
    chk("R4", "rx ready follows sink", rx_in_ready, 0);
    chk("R4", "tx data passes", tx_out_data, 8'hC3);
    chk("R4", "tx ready follows sink", tx_in_ready, 0);
    rx_out_ready = 1'b1; #1;
    chk("R4", "rx ready follows sink high", rx_in_ready, 1);
    rx_in_valid = 1'b0; tx_in_valid = 1'b0; rx_out_ready = 1'b0;
    @(negedge clk);
    chk("R6", "flag held before read", status_flag, 1);
    rd_st();
    chk("R6", "read when stable clears", status_flag, 0);
  endtask

  task automatic t_count_read();
    rd_cn();
    chk("R8", "count cleared", disc_count, 0);
    ev(0); ev(0);
    rd_count = 1'b1;
    ev(0);
    rd_count = 1'b0;
    chk("R8", "read with entry gives 1", disc_count, 1);
    chk("R6", "flag set again", status_flag, 1);
    ev(1); ev(1);
    chk("R5", "recovered", link_unstable, 0);
  endtask

  task automatic t_th_zero();
    bad_th = 4'd0; good_th = 4'd0;
    ev(0);
    chk("R3", "zero threshold acts as one", link_unstable, 1);
    ev(1);
    chk("R5", "zero good threshold acts as one", link_unstable, 0);
    chk("R7", "count two", disc_count, 2);
  endtask

  task automatic t_disable();
    ev(0);
    chk("R3", "unstable before disable", link_unstable, 1);
    wr_off(1'b1);
    @(negedge clk);
    chk("R9", "disable releases link", link_unstable, 0);
    chk("R9", "release does not count", disc_count, 3);
    rd_st();
    chk("R6", "flag cleared", status_flag, 0);
    ev(0); ev(0); ev(0);
    rx_in_valid = 1'b1; rx_out_ready = 1'b0; #1;
    chk("R9", "disabled never unstable", link_unstable, 0);
    chk("R9", "disabled rx passes", rx_out_valid, 1);
    chk("R9", "disabled flag stays", status_flag, 0);
    chk("R9", "disabled count stays", disc_count, 3);
    rx_in_valid = 1'b0;
    wr_off(1'b0);
    @(negedge clk);
  endtask

  task automatic t_saturate();
    bad_th = 4'd1; good_th = 4'd1;
    rd_cn();
    for (int i = 0; i < 260; i++) begin
      ev(0); ev(1);
    end
    chk("R7", "count saturates", disc_count, 255);
    ev(0);
    chk("R7", "count holds at max", disc_count, 255);
    ev(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sw_write();
    t_enter();
    t_gate_closed();
    t_read_unstable();
    t_recover();
    t_count_read();
    t_th_zero();
    t_disable();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule